// File: doc/BRIEF.md
# Cross-Domain Ready Strobe Word Loader

This block sits in a fast system clock domain and takes in words produced by an unrelated, slower source clock domain. The source raises a ready strobe while a data word is held stable. The strobe is captured by a single synchronizing flip-flop. A small control state machine then turns each synchronized rising edge into exactly one load enable. That enable writes the word into an input register.

A strobe may stay high for many system clocks, because the source clock is slower. Even so, the block issues one load per strobe and waits for the strobe to drop before it can accept another. The state machine walks a four-state Gray-coded loop, so every transition changes one state bit only. A late sample of the strobe therefore delays the load by a cycle and never moves the machine into a wrong state. The loaded word appears together with a one-cycle valid pulse.

The states are IDLE (00), LOAD (01), HOLD (11) and DRAIN (10). The transitions are:

- IDLE to LOAD when the synchronized strobe is high.
- LOAD to HOLD always. The load enable is active during LOAD.
- HOLD to DRAIN when the synchronized strobe is low.
- DRAIN to IDLE always.

In every other case the machine stays in its current state.

Top module: `xdl_word_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first load, `load_valid` is 0 and `load_word` is all zeros. The state machine starts in IDLE.
- R2: `src_rdy` reaches the control logic only through one synchronizing flip-flop. Let edge k be the first rising clock edge at which that flip-flop captures `src_rdy` high. Then `load_valid` is 1 after edge k+2.
- R3: Each strobe produces exactly one load, however many clocks it stays high.
- R4: The states are encoded IDLE=00, LOAD=01, HOLD=11, DRAIN=10. Each clock the state changes by at most one bit.
- R5: A load starts only from IDLE when the synchronized strobe is high. The machine leaves HOLD only once the synchronized strobe is low.
- R6: `load_valid` is high for exactly one clock per load. In that clock, `load_word` equals the value `src_word` had at the edge that raised `load_valid`.
- R7: In every clock where `load_valid` is 0, `load_word` keeps its previous value.
- R8: No word is lost or duplicated when the strobe's high and low times are each at least three system clocks. This also holds when consecutive words carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_rdy | input | 1 | Ready strobe from the source clock domain (asynchronous) |
| src_word | input | 32 | Source data word, stable while `src_rdy` is high |
| load_word | output | 32 | Registered word from the most recent load |
| load_valid | output | 1 | One-clock pulse marking a fresh `load_word` |

## Verification
The assertions check the following on every clock:
- the one-bit-per-step Gray discipline of the state register;
- a load enable is always preceded by a synchronized high strobe;
- the enable never repeats on consecutive clocks or while HOLD sees the strobe still high;
- the output word changes only together with the valid pulse.

Other properties can only be shown by the bench scenarios. These are:
- the exact two-clock latency after synchronization;
- the count of loads against the count of words sent, over strobes of different lengths and gaps under a non-integer clock ratio;
- correct handling of repeated identical words.

// File: rtl/xdl_pkg.sv
package xdl_pkg;

    // Gray-coded control states: each legal step flips one bit
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_LOAD  = 2'b01,
        ST_HOLD  = 2'b11,
        ST_DRAIN = 2'b10
    } ld_state_t;

endpackage

// File: rtl/xdl_rdy_sync.sv
module xdl_rdy_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    // single capture stage; resolution time is the full clock period
    always_ff @(posedge clk) begin
        if (!rst_n) sync_out <= 1'b0;
        else        sync_out <= async_in;
    end

endmodule

// File: rtl/xdl_load_fsm.sv
module xdl_load_fsm
    import xdl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_s,
    output logic load_en
);

    ld_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (rdy_s)  state_nx = ST_LOAD;
            ST_LOAD:              state_nx = ST_HOLD;
            ST_HOLD:  if (!rdy_s) state_nx = ST_DRAIN;
            ST_DRAIN:             state_nx = ST_IDLE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    // outputs (Moore)
    always_comb begin
        load_en = 1'b0;
        unique case (state)
            ST_LOAD: load_en = 1'b1;
            default: load_en = 1'b0;
        endcase
    end

    // R4: only one state bit flips per clock
    a_r4_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state ^ $past(state)) <= 1);

    // R5: a load is always preceded by a synchronized high strobe
    a_r5_load_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> $past(rdy_s));

    // R3: the load enable never lasts two clocks
    a_r3_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !load_en);

    // R5: HOLD with strobe still high never reloads and never leaves
    a_r5_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && rdy_s) |=> (!load_en && state == ST_HOLD));

endmodule

// File: rtl/xdl_word_reg.sv
module xdl_word_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= load_en;
            if (load_en) dout <= din;
        end
    end

    // R6: a valid clock shows the word sampled at that edge
    a_r6_word_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |-> (dout == $past(din)));

    // R7: without valid the word holds
    a_r7_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid |-> $stable(dout));

endmodule

// File: rtl/xdl_word_loader.sv
module xdl_word_loader #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_rdy,
    input  logic [DATA_W-1:0] src_word,
    output logic [DATA_W-1:0] load_word,
    output logic              load_valid
);

    logic rdy_s;
    logic load_en;

    xdl_rdy_sync i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_rdy),
        .sync_out (rdy_s)
    );

    xdl_load_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdy_s   (rdy_s),
        .load_en (load_en)
    );

    xdl_word_reg #(.DATA_W(DATA_W)) i_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .din     (src_word),
        .dout    (load_word),
        .dvalid  (load_valid)
    );

    // R6: valid never lasts two clocks
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> !load_valid);

endmodule

// File: tb/test_xdl_word_loader.sv
`timescale 1ns/1ps
module test_xdl_word_loader;

    logic        clk = 1'b0;
    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_rdy = 1'b0;
    logic [31:0] src_word = 32'h0;
    logic [31:0] load_word;
    logic        load_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int n_sent   = 0;
    int n_loads  = 0;
    bit done     = 1'b0;

    logic [31:0] sent_q[$];

    // reference model state
    logic        m_sync = 1'b0, m_sync_d = 1'b0, m_pend = 1'b0;
    logic        exp_valid = 1'b0;
    logic [31:0] exp_word = 32'h0;

    always #10 clk = ~clk;    // 50 MHz system clock, rising edges on even ns
    always #33 sclk = ~sclk;  // 66 ns source clock, ratio 3.3

    xdl_word_loader i_xdl_word_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_rdy    (src_rdy),
        .src_word   (src_word),
        .load_word  (load_word),
        .load_valid (load_valid)
    );

    // behavioural model: edge detect on a sampled strobe, load two edges later
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sync <= 1'b0; m_sync_d <= 1'b0; m_pend <= 1'b0;
            exp_valid <= 1'b0; exp_word <= 32'h0;
        end else begin
            m_sync    <= src_rdy;
            m_sync_d  <= m_sync;
            m_pend    <= m_sync && !m_sync_d;
            exp_valid <= m_pend;
            if (m_pend) exp_word <= src_word;
        end
    end

    // cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (load_valid !== exp_valid) begin
                n_fail++;
                $display("FAIL R2/R6 valid: actual %0b expected %0b at %0t", load_valid, exp_valid, $time);
            end
            n_checks++;
            if (load_word !== exp_word) begin
                n_fail++;
                $display("FAIL R6/R7 word: actual %h expected %h at %0t", load_word, exp_word, $time);
            end
            if (rst_n && load_valid === 1'b1) begin
                n_loads++;
                n_checks++;
                if (sent_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R3 extra load: actual %h expected none", load_word);
                end else begin
                    logic [31:0] w;
                    w = sent_q.pop_front();
                    if (load_word !== w) begin
                        n_fail++;
                        $display("FAIL R8 order: actual %h expected %h", load_word, w);
                    end
                end
            end
        end
    end

    task automatic send(input logic [31:0] w, input int hi, input int lo);
        src_word = w;
        src_rdy  = 1'b1;
        sent_q.push_back(w);
        n_sent++;
        repeat (hi) @(posedge sclk);
        #2;
        src_rdy = 1'b0;
        repeat (lo) @(posedge sclk);
        #2;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            n_checks++;
            if (load_valid !== 1'b0 || load_word !== 32'h0) begin
                n_fail++;
                $display("FAIL R1 reset: actual %0b/%h expected 0/00000000", load_valid, load_word);
            end
        end
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(posedge sclk); #2;

        // R2/R6 nominal, then R3 long strobes, short strobes, gaps
        send(32'hA5A5_5A5A, 2, 2);
        send(32'h0000_0001, 2, 2);
        send(32'hFFFF_FFFF, 1, 1);   // R8 shortest high and low
        send(32'h1234_5678, 8, 3);   // R3 long strobe, one load
        send(32'h1234_5678, 2, 2);   // R8 same value repeated
        send(32'h0000_0000, 1, 6);
        send(32'hDEAD_BEEF, 5, 1);
        for (int i = 0; i < 10; i++)
            send(32'h0101_0101 * (i + 1), 1 + (i % 3), 1 + (i % 2));
        repeat (20) @(posedge sclk);
        send(32'hCAFE_F00D, 12, 4);  // R3 very long strobe after idle
        repeat (10) @(posedge clk);
        @(negedge clk);

        // R3/R8: totals
        n_checks++;
        if (n_loads != n_sent || sent_q.size() != 0) begin
            n_fail++;
            $display("FAIL R3/R8 count: actual %0d loads expected %0d", n_loads, n_sent);
        end
        finish_run();
    end

    initial begin
        #(200000 * 20);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule